// File: doc/BRIEF.md
# Read Prefetch and Burst Controller

This block serves a read from a local bus master to the PCI side through a 16-longword read FIFO. When the local master starts a read, the controller captures the start address, the byte enables and the configuration. It then decides how many PCI longwords to fetch. A single-phase read fetches one longword. With prefetch off, it fetches one longword for each data phase as that phase needs it. With prefetch on, it fetches ahead by a fixed count (4, 8 or 16) or keeps fetching without a fixed count.

Local ready is asserted only while a longword is waiting in the FIFO, so the local master is held off while data is still being collected. The local burst-last flag on a completed data phase ends the cycle and discards whatever prefetched data is left. An optional page limit keeps speculative fetches inside the current 4 KB page. The PCI side is modelled as a simple request/acknowledge pair that moves one longword per acknowledge.

Top module: `rd_prefetch_ctrl`

## Requirements
- R1: After reset, `pci_req` and `lcl_ready` are low and the controller is idle.
- R2: `lcl_ready` is high only while at least one fetched longword is in the FIFO. The k-th completed data phase of a cycle returns the longword fetched from address base+4k, where base is `lcl_addr` with its two low bits cleared.
- R3: If `lcl_last` is high on the first data phase, exactly one PCI longword is fetched and `pci_be` equals the `lcl_be` captured at the start.
- R4: On a cycle of two or more data phases, every request carries `pci_be` = 4'b1111, whatever the local byte enables are.
- R5: With `cfg_pf_en` low, one longword is fetched for each data phase and only when that phase finds the FIFO empty. An L-phase cycle makes exactly L requests.
- R6: With prefetch on and `cfg_pf_mode` 0, 1 or 2, the controller fetches ahead to a total of 4, 8 or 16 longwords (the first included). Further longwords are fetched only on demand, so an L-phase cycle makes max(L, count) requests.
- R7: With `cfg_pf_mode` 3 (continuous), fetching pauses while 16 longwords sit in the FIFO and resumes as they drain. The FIFO never overflows.
- R8: With `cfg_page_lim` high, no speculative fetch is made for an address in the next 4 KB page. A prefetching cycle that starts W longwords before the page end fetches at most W longwords ahead.
- R9: On the data phase that completes with `lcl_last` high, the FIFO is emptied at once. An outstanding request is completed and its data dropped. The next cycle sees only its own data.
- R10: Once raised, `pci_req`, `pci_addr` and `pci_be` stay unchanged until the cycle in which `pci_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pf_en | input | 1 | Prefetch enable |
| cfg_pf_mode | input | 2 | 0: 4, 1: 8, 2: 16 longwords, 3: continuous |
| cfg_page_lim | input | 1 | Stop speculative fetches at 4 KB page end |
| lcl_req | input | 1 | Local data phase pending; held until ready |
| lcl_last | input | 1 | Current data phase is the last of the cycle |
| lcl_addr | input | 32 | Start byte address of the cycle |
| lcl_be | input | 4 | Local byte enables |
| lcl_ready | output | 1 | Data phase completes this cycle when lcl_req is high |
| lcl_rdata | output | 32 | Read data at the FIFO head |
| pci_req | output | 1 | PCI longword read request |
| pci_addr | output | 32 | PCI longword address |
| pci_be | output | 4 | PCI byte enables |
| pci_ack | input | 1 | Request completes; pci_rdata valid |
| pci_rdata | input | 32 | PCI read data |

## Verification
The assertions rely on four conditions at the inputs. The local master keeps `lcl_req` high until a ready cycle. Address, byte enables and configuration stay still during a cycle. `pci_ack` appears only while `pci_req` is high. A local burst never runs past the end of its 4 KB page. The bench drives the local side through one task that raises `lcl_req` and holds it until ready. It changes configuration only between cycles, after a quiet gap. Its PCI responder acknowledges only a raised request. It chooses burst lengths no larger than the words left in the page.

// File: rtl/rd_prefetch_ctrl.sv
module rd_prefetch_ctrl #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int DEPTH = 16,
  parameter int PAGE_BITS = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_pf_en,
  input  logic [1:0]    cfg_pf_mode,
  input  logic          cfg_page_lim,
  input  logic          lcl_req,
  input  logic          lcl_last,
  input  logic [AW-1:0] lcl_addr,
  input  logic [3:0]    lcl_be,
  output logic          lcl_ready,
  output logic [DW-1:0] lcl_rdata,
  output logic          pci_req,
  output logic [AW-1:0] pci_addr,
  output logic [3:0]    pci_be,
  input  logic          pci_ack,
  input  logic [DW-1:0] pci_rdata
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam int FW = CW + 1;

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_DRAIN} st_t;

  st_t st;
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [AW-1:0] nxt_addr;
  logic [3:0]    be_q;
  logic          single_q, pf_q, cont_q, lim_q;
  logic [FW-1:0] fcnt, nmax;

  logic push, pop, done, at_edge, spec, demand, issue;

  assign lcl_ready = (st == S_ACT) && (cnt != '0);
  assign lcl_rdata = mem[rp];
  assign push    = (st == S_ACT) && pci_req && pci_ack;
  assign pop     = lcl_req && lcl_ready;
  assign done    = pop && lcl_last;
  assign at_edge = lim_q && (fcnt != '0) && (nxt_addr[PAGE_BITS-1:2] == '0);
  assign spec    = pf_q && !single_q && (cont_q || fcnt < nmax)
                   && (cnt < CW'(DEPTH)) && !at_edge;
  assign demand  = lcl_req && (cnt == '0);
  assign issue   = (st == S_ACT) && !pci_req && !done && (spec || demand);

  always_ff @(posedge clk)
    if (push && !done) mem[wp] <= pci_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      pci_req  <= 1'b0;
      pci_addr <= '0;
      pci_be   <= '0;
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      fcnt     <= '0;
      nmax     <= '0;
      nxt_addr <= '0;
      be_q     <= '0;
      single_q <= 1'b0;
      pf_q     <= 1'b0;
      cont_q   <= 1'b0;
      lim_q    <= 1'b0;
    end else begin
      if (pci_req && pci_ack) pci_req <= 1'b0;
      case (st)
        S_IDLE: if (lcl_req) begin
          st       <= S_ACT;
          nxt_addr <= lcl_addr & ~AW'(3);
          be_q     <= lcl_be;
          single_q <= lcl_last;
          pf_q     <= cfg_pf_en;
          cont_q   <= (cfg_pf_mode == 2'd3);
          lim_q    <= cfg_page_lim;
          fcnt     <= '0;
          case (cfg_pf_mode)
            2'd0:    nmax <= FW'(DEPTH / 4);
            2'd1:    nmax <= FW'(DEPTH / 2);
            default: nmax <= FW'(DEPTH);
          endcase
        end
        S_ACT: begin
          if (issue) begin
            pci_req  <= 1'b1;
            pci_addr <= nxt_addr;
            pci_be   <= single_q ? be_q : 4'hF;
            nxt_addr <= nxt_addr + AW'(4);
            if (fcnt != '1) fcnt <= fcnt + 1'b1;
          end
          if (done) begin
            st   <= (pci_req && !pci_ack) ? S_DRAIN : S_IDLE;
            wp   <= '0;
            rp   <= '0;
            cnt  <= '0;
            fcnt <= '0;
          end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            cnt <= cnt + CW'(push) - CW'(pop);
          end
        end
        default: if (pci_ack) st <= S_IDLE;
      endcase
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pci_req && !pci_ack |=> pci_req && $stable(pci_addr) && $stable(pci_be));
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < CW'(DEPTH)) || pop);
  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cnt == '0) && (st != S_ACT) && !lcl_ready);
  // R3
  single_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACT) && single_q |-> fcnt <= FW'(1));
  // R4
  full_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pci_req && (pci_be != 4'hF) |-> single_q);
  // R8
  page_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_req) && lim_q && (pci_addr[PAGE_BITS-1:2] == '0) && (fcnt > FW'(1))
      |-> $past(lcl_req));
endmodule

// File: tb/test_rd_prefetch_ctrl.sv
module test_rd_prefetch_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_pf_en = 1'b0, cfg_page_lim = 1'b0;
  logic [1:0] cfg_pf_mode = 2'd0;
  logic lcl_req = 1'b0, lcl_last = 1'b0;
  logic [31:0] lcl_addr = '0;
  logic [3:0] lcl_be = '0;
  logic lcl_ready, pci_req, pci_ack = 1'b0;
  logic [31:0] lcl_rdata, pci_addr, pci_rdata = '0;
  logic [3:0] pci_be;

  int n_chk = 0, n_bad = 0;
  int acks = 0, be_bad = 0, hold_bad = 0;
  logic [3:0] exp_be = 4'hF;

  always #2 clk = ~clk;

  rd_prefetch_ctrl i_rd_prefetch_ctrl (.*);

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_3C3C;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin : responder
    forever begin
      @(negedge clk);
      if (pci_req) begin
        logic [31:0] a0;
        logic [3:0] b0;
        a0 = pci_addr;
        b0 = pci_be;
        repeat (acks % 3) @(negedge clk);
        if (pci_addr !== a0 || pci_be !== b0 || !pci_req) hold_bad++;
        if (pci_be !== exp_be) be_bad++;
        pci_ack = 1'b1;
        pci_rdata = pat(pci_addr);
        acks++;
        @(posedge clk);
        #1 pci_ack = 1'b0;
      end
    end
  end

  task automatic phase(input bit last, output logic [31:0] got);
    @(negedge clk);
    lcl_req = 1'b1;
    lcl_last = last;
    #1;
    while (!lcl_ready) @(negedge clk);
    got = lcl_rdata;
    @(posedge clk);
    #1 lcl_req = 1'b0;
    lcl_last = 1'b0;
  endtask

  task automatic burst(input logic [31:0] base, input int len, input bit pf,
                       input logic [1:0] mode, input bit lim);
    logic [31:0] got;
    int words, s_cnt, p_exp, t_exp;
    cfg_pf_en = pf;
    cfg_pf_mode = mode;
    cfg_page_lim = lim;
    lcl_addr = base;
    lcl_be = (len == 1) ? 4'b0110 : 4'b0011;
    exp_be = (len == 1) ? 4'b0110 : 4'hF;
    acks = 0;
    be_bad = 0;
    hold_bad = 0;
    words = (4096 - int'(base[11:0])) / 4;
    s_cnt = (mode == 2'd3) ? 17 : (4 << mode);
    if (lim && words < s_cnt) s_cnt = words;
    p_exp = pf ? s_cnt : 1;
    t_exp = pf ? ((len > s_cnt) ? len : s_cnt) : len;
    for (int k = 0; k < len; k++) begin
      phase(k == len - 1, got);
      // R2: data returned in address order
      chk(got === pat(base + 32'(4 * k)), "R2 data order", got, pat(base + 32'(4 * k)));
      if (k == 0 && len > 1) begin
        repeat (100) @(negedge clk);
        // R5 R6 R7 R8: longwords fetched ahead while the master pauses
        chk(acks == p_exp, "R6/R7/R8 prefetch depth", 32'(acks), 32'(p_exp));
      end
    end
    repeat (30) @(negedge clk);
    if (len == 1)
      // R3: single phase fetches one longword
      chk(acks == 1, "R3 single fetch count", 32'(acks), 32'd1);
    else if (!(pf && mode == 2'd3))
      // R5 R6: total fetch count
      chk(acks == t_exp, "R5/R6 total fetch count", 32'(acks), 32'(t_exp));
    // R3 R4: byte enables on every request
    chk(be_bad == 0, (len == 1) ? "R3 byte enables" : "R4 byte enables", 32'(be_bad), 32'd0);
    // R10: request stable until acknowledged
    chk(hold_bad == 0, "R10 request hold", 32'(hold_bad), 32'd0);
    // R9: idle and empty after the last phase
    chk(!lcl_ready && !pci_req, "R9 flushed idle", {30'd0, lcl_ready, pci_req}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int lens [4] = '{1, 2, 5, 9};
    logic [31:0] bases [2] = '{32'h0001_0040, 32'h0003_0FD8};
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!pci_req && !lcl_ready, "R1 reset outputs", {30'd0, pci_req, lcl_ready}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!pci_req && !lcl_ready, "R1 idle after reset", {30'd0, pci_req, lcl_ready}, 32'd0);
    for (int pf = 0; pf < 2; pf++)
      for (int m = 0; m < 4; m++)
        for (int lim = 0; lim < 2; lim++)
          for (int b = 0; b < 2; b++)
            for (int l = 0; l < 4; l++)
              burst(bases[b], lens[l], pf[0], m[1:0], lim[0]);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule